// File: doc/BRIEF.md
# Dual-Rail Four-Phase Pipeline FIFO

This block is a clock-sampled model of a self-timed, latch-free FIFO. Ten identical stages each hold either one word of four dual-rail bits or a spacer. A stage has no storage beyond its own output node. Its precharge/evaluate control is the done signal of the stage after it. A stage is forced back to spacer once its successor has captured valid data. It may take a new word from its predecessor only while its successor shows spacer.

The sender drives a complete dual-rail word, which is the request, and waits for `in_ack` to rise. It then drives an all-spacer word and waits for `in_ack` to fall before it offers the next word. The receiver sees a word on `out_rails` and raises `out_ack`. It lowers `out_ack` once the output has returned to spacer. Each stage event takes one clock tick, and a stage reacts on a tick only to conditions that held at the previous tick. Every word must be separated from the next by a spacer, so a pipeline with DEPTH stages holds at most DEPTH/2 words.

Top module: `dualrail_fifo`

## Requirements
- R1: Bit i of a word travels on rails [2i+1] (true) and [2i] (false). Logic 1 is (1,0), logic 0 is (0,1) and spacer is (0,0). A word is complete when every bit is 1 or 0, and it is spacer when every rail is low.
- R2: An input word in which any bit carries (1,1) is never captured: `in_ack` stays low and nothing reaches `out_rails`. No stage ever holds a (1,1) pair.
- R3: An input word that mixes spacer bits and valid bits is not captured until it is complete. No stage holds such a mix for more than one tick.
- R4: After synchronous reset every stage holds spacer, so `out_rails` is all zero and `in_ack` is low.
- R5: In an empty pipeline with `out_ack` low, a word first presented before rising edge 1 is complete on `out_rails` after rising edge DEPTH.
- R6: A word on `out_rails` stays unchanged while `out_ack` is low. The output returns to spacer on the first rising edge at which `out_ack` is high.
- R7: Words leave in the order they entered, with none lost and none duplicated, for any pattern of sender gaps and receiver stalls.
- R8: With `out_ack` held low, the FIFO acknowledges exactly DEPTH/2 words. The next word is not acknowledged until the receiver drains the FIFO.
- R9: A stage evaluates only while its successor shows spacer, and precharges only after its successor shows done. In an empty pipeline `in_ack` is therefore high for exactly two ticks per word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model tick clock |
| rst | input | 1 | Synchronous active-high reset |
| in_rails | input | 2*W | Dual-rail word or spacer from the sender |
| in_ack | output | 1 | Done of the first stage, acknowledging the sender |
| out_rails | output | 2*W | Dual-rail word or spacer of the last stage |
| out_ack | input | 1 | Receiver acknowledge, used as the last stage's successor done |

## Verification
A single word sent into an empty pipeline fixes the forward latency. The same test gives the two-tick acknowledge pulse, which shows the precharge/evaluate sequencing between neighbouring stages. Incomplete words and words carrying an illegal pair are held on the input for many ticks, which shows whether capture waits for a complete, legal word. With the receiver stalled, a fill test counts how many words are acknowledged and so tells a spacer-separated pipeline from one that packs words. A table-driven stream with varied gaps, stalls and repeated equal words shows whether order is kept, whether any word is lost and whether a word held on the input is captured twice.

// File: rtl/dualrail_pkg.sv
package dualrail_pkg;
  typedef enum logic {PH_EVALUATE = 1'b0, PH_PRECHARGE = 1'b1} stage_phase_t;

  function automatic logic pair_valid(input logic [1:0] p);
    return p[1] ^ p[0];
  endfunction

  function automatic logic pair_bad(input logic [1:0] p);
    return p[1] & p[0];
  endfunction
endpackage

// File: rtl/dualrail_done.sv
module dualrail_done #(
  parameter int W           = 4,
  parameter bit FULL_DETECT = 1'b1,
  parameter int OBS_BIT     = 0
) (
  input  logic [2*W-1:0] rails,
  output logic           done
);
  import dualrail_pkg::*;

  generate
    if (FULL_DETECT) begin : g_full
      logic [W-1:0] bit_ok;
      for (genvar b = 0; b < W; b++) begin : g_bit
        assign bit_ok[b] = pair_valid(rails[2*b +: 2]);
      end
      assign done = &bit_ok;
    end else begin : g_single
      assign done = pair_valid(rails[2*OBS_BIT +: 2]);
    end
  endgenerate
endmodule

// File: rtl/dualrail_stage.sv
module dualrail_stage #(
  parameter int W           = 4,
  parameter bit FULL_DETECT = 1'b1,
  parameter int OBS_BIT     = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*W-1:0] up_rails,
  input  logic           succ_done,
  output logic [2*W-1:0] node_rails,
  output logic           done
);
  import dualrail_pkg::*;

  localparam int RW = 2 * W;

  logic [RW-1:0] node;
  logic [W-1:0]  node_valid;
  logic          up_complete;
  logic          node_busy;
  logic          node_bad;
  logic          node_mixed;
  stage_phase_t  phase;

  always_comb begin
    up_complete = 1'b1;
    node_bad    = 1'b0;
    for (int b = 0; b < W; b++) begin
      up_complete   = up_complete & pair_valid(up_rails[2*b +: 2]);
      node_valid[b] = pair_valid(node[2*b +: 2]);
      node_bad      = node_bad | pair_bad(node[2*b +: 2]);
    end
    node_busy  = |node;
    node_mixed = (|node_valid) && !(&node_valid);
    phase      = succ_done ? PH_PRECHARGE : PH_EVALUATE;
  end

  // The node is the emulated dynamic output: it evaluates once from a
  // complete input and keeps that value until its successor reports done.
  always_ff @(posedge clk) begin
    if (rst) begin
      node <= '0;
    end else if (phase == PH_PRECHARGE) begin
      node <= '0;
    end else if (!node_busy && up_complete) begin
      node <= up_rails;
    end
  end

  assign node_rails = node;

  dualrail_done #(.W(W), .FULL_DETECT(FULL_DETECT), .OBS_BIT(OBS_BIT)) u_done (
    .rails (node),
    .done  (done)
  );

  a_r2_no_illegal_pair: assert property (@(posedge clk) disable iff (rst)
    !node_bad);

  a_r3_no_lasting_mix: assert property (@(posedge clk) disable iff (rst)
    node_mixed |=> !node_mixed);

  a_r7_value_held: assert property (@(posedge clk) disable iff (rst)
    ((|$past(node)) && (|node)) |-> (node == $past(node)));

  a_r9_eval_gated: assert property (@(posedge clk) disable iff (rst)
    (!(|$past(node)) && (|node)) |-> !$past(succ_done));

  a_r9_prech_gated: assert property (@(posedge clk) disable iff (rst)
    ((|$past(node)) && !(|node)) |-> $past(succ_done));
endmodule

// File: rtl/dualrail_fifo.sv
module dualrail_fifo #(
  parameter int W           = 4,
  parameter int DEPTH       = 10,
  parameter bit FULL_DETECT = 1'b1,
  parameter int OBS_BIT     = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*W-1:0] in_rails,
  output logic           in_ack,
  output logic [2*W-1:0] out_rails,
  input  logic           out_ack
);
  localparam int RW = 2 * W;

  logic [RW-1:0] chain [DEPTH+1];
  logic [DEPTH:0] stage_done;

  assign chain[0]          = in_rails;
  assign stage_done[DEPTH] = out_ack;

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      dualrail_stage #(.W(W), .FULL_DETECT(FULL_DETECT), .OBS_BIT(OBS_BIT)) u_stage (
        .clk        (clk),
        .rst        (rst),
        .up_rails   (chain[s]),
        .succ_done  (stage_done[s+1]),
        .node_rails (chain[s+1]),
        .done       (stage_done[s])
      );
    end
  endgenerate

  assign in_ack    = stage_done[0];
  assign out_rails = chain[DEPTH];

  a_r6_output_waits: assert property (@(posedge clk) disable iff (rst)
    ((|out_rails) && !out_ack) |=> (out_rails == $past(out_rails)));

  a_r6_output_clears: assert property (@(posedge clk) disable iff (rst)
    ((|out_rails) && out_ack) |=> (out_rails == '0));
endmodule

// File: tb/sim_dualrail_fifo.sv
`timescale 1ns/1ps
module sim_dualrail_fifo;
  localparam int W     = 4;
  localparam int DEPTH = 10;
  localparam int RW    = 2 * W;

  // {word, sender gap, receiver stall}
  localparam logic [11:0] VEC [16] = '{
    12'hA00, 12'h501, 12'h5_1_0, 12'hF32, 12'h004, 12'h3_0_0, 12'hC21,
    12'h7_0_5, 12'h7_1_0, 12'h902, 12'h1_4_0, 12'hE03, 12'h2_0_1,
    12'h6_2_6, 12'hB00, 12'h4_1_2
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RW-1:0] in_rails = '0;
  logic in_ack;
  logic [RW-1:0] out_rails;
  logic out_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dualrail_fifo #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .in_rails(in_rails), .in_ack(in_ack),
    .out_rails(out_rails), .out_ack(out_ack)
  );

  function automatic logic [RW-1:0] enc(input logic [W-1:0] w);
    logic [RW-1:0] r;
    for (int i = 0; i < W; i++) begin
      r[2*i+1] = w[i];
      r[2*i]   = ~w[i];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] dec(input logic [RW-1:0] r);
    logic [W-1:0] w;
    for (int i = 0; i < W; i++) w[i] = r[2*i+1];
    return w;
  endfunction

  function automatic bit complete(input logic [RW-1:0] r);
    bit c = 1'b1;
    for (int i = 0; i < W; i++) c = c & (r[2*i+1] ^ r[2*i]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [W-1:0] w, input int gap, input int limit, output bit ok);
    ok = 1'b0;
    in_rails = enc(w);
    for (int i = 0; i < limit && !in_ack; i++) @(negedge clk);
    if (!in_ack) return;
    in_rails = '0;
    for (int i = 0; i < 400 && in_ack; i++) @(negedge clk);
    ok = !in_ack;
    repeat (gap) @(negedge clk);
  endtask

  task automatic recv(input logic [W-1:0] exp, input int stall);
    logic [RW-1:0] held;
    bit stable = 1'b1;
    for (int i = 0; i < 400 && !complete(out_rails); i++) @(negedge clk);
    chk(complete(out_rails) == 1'b1, "R7 word arrives", int'(complete(out_rails)), 1);
    chk(dec(out_rails) == exp, "R7 order", int'(dec(out_rails)), int'(exp));
    held = out_rails;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      if (out_rails != held) stable = 1'b0;
    end
    chk(stable, "R6 held while stalled", int'(out_rails), int'(held));
    out_ack = 1'b1;
    @(negedge clk);
    chk(out_rails == '0, "R6 clears after ack", int'(out_rails), 0);
    out_ack = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL R7 watchdog expired: actual %0d expected %0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lat;
    int ack_hi;
    int acc;
    bit ok;
    bit quiet;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4 reset state
    chk(out_rails == '0, "R4 output spacer", int'(out_rails), 0);
    chk(in_ack == 1'b0, "R4 in_ack low", int'(in_ack), 0);

    // R5 latency and R9 acknowledge pulse on an empty pipeline
    in_rails = enc(4'hA);
    lat = 0;
    ack_hi = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      lat++;
      if (in_ack) begin
        ack_hi++;
        in_rails = '0;
      end
      if (complete(out_rails)) break;
    end
    chk(lat == DEPTH, "R5 latency", lat, DEPTH);
    chk(ack_hi == 2, "R9 in_ack ticks", ack_hi, 2);
    chk(dec(out_rails) == 4'hA, "R1 decoded value", int'(dec(out_rails)), 10);
    recv(4'hA, 3);
    repeat (4) @(negedge clk);

    // R3 incomplete word: bit0 = 1, other bits spacer
    in_rails = 8'b0000_0010;
    quiet = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (in_ack || out_rails != '0) quiet = 1'b0;
    end
    chk(quiet, "R3 partial word ignored", int'(in_ack), 0);

    // R2 illegal (1,1) on bit2
    in_rails = enc(4'h5) | 8'b0011_0000;
    quiet = 1'b1;
    repeat (20) begin
      @(negedge clk);
      if (in_ack || out_rails != '0) quiet = 1'b0;
    end
    chk(quiet, "R2 illegal word ignored", int'(in_ack), 0);
    in_rails = '0;
    repeat (4) @(negedge clk);

    // R8 capacity with the receiver stalled
    acc = 0;
    for (int k = 0; k < 6; k++) begin
      send(VEC[k][11:8], 0, 40, ok);
      if (ok) acc++;
      else break;
    end
    chk(acc == DEPTH / 2, "R8 words accepted", acc, DEPTH / 2);
    chk(in_ack == 1'b0, "R8 extra word waits", int'(in_ack), 0);
    fork
      begin
        for (int i = 0; i < 400 && !in_ack; i++) @(negedge clk);
        in_rails = '0;
        for (int i = 0; i < 400 && in_ack; i++) @(negedge clk);
      end
      begin
        for (int k = 0; k < 6; k++) recv(VEC[k][11:8], 1);
      end
    join
    repeat (4) @(negedge clk);

    // R7 table stream: gaps and stalls vary, equal words repeat
    fork
      begin
        for (int k = 0; k < 16; k++) begin
          send(VEC[k][11:8], int'(VEC[k][7:4]), 400, ok);
          chk(ok, "R7 sender handshake", int'(ok), 1);
        end
      end
      begin
        for (int k = 0; k < 16; k++) recv(VEC[k][11:8], int'(VEC[k][3:0]));
      end
    join
    quiet = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (out_rails != '0) quiet = 1'b0;
    end
    chk(quiet, "R7 no duplicate", int'(out_rails), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule